// File: doc/BRIEF.md
# Digital LDO Adaptive-Rate Controller

This block is the clocked control logic of a digitally controlled low-dropout regulator. On each of its own sampling ticks it reads one comparator bit that says whether the regulated output sits below or above its target. It then enables one more parallel power switch, or one fewer. Every switch enable is a plain on/off line, so the delivered current is set only by how many switches are on. The switches are always taken in thermometer order, so the same ones turn on first.

The sampling tick comes from a divider on the fast controller clock. In steady state it runs at a slow ratio. Two alarm inputs report a droop past a low threshold and an overshoot past a high threshold. Either alarm moves the block to a fast ratio. Once the alarms clear, the block stays fast for a programmable number of fast ticks and then falls back to the slow ratio. Software enables the loop. A bypass request closes the head switch, which ties the load straight to the input rail, and freezes regulation. Each time the loop starts, the switch count begins from a programmable starting value.

Top module: `dldo_rate_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the block clears itself: after that edge sw_en is all zero, head_sw is 0 and status is 0.
- R2: If en is low at a clock edge, then after that edge sw_en is zero, head_sw is 0 and the mode field status[5:4] is 2'b00 (off) with count field status[3:0] zero.
- R3: If en and bypass_req are high at a clock edge, then after that edge head_sw is 1, sw_en is zero and the mode field is 2'b01 (bypass). Bypass wins over the alarms.
- R4: At the first edge where en is high and bypass_req is low, coming from off or bypass, the mode becomes 2'b10 (slow). The count becomes init_count, clamped to N_SW.
- R5: While regulating, a tick occurs every slow_div cycles in slow mode and every fast_div cycles in fast mode; a ratio of 0 acts as 1. The count changes only at edges where a tick occurs.
- R6: At a tick, cmp_low=1 (output below target) raises the count by one and stops at N_SW. cmp_low=0 lowers it by one and stops at 0.
- R7: While regulating, sw_en[i] is 1 exactly when i is less than the count. status[3:0] shows that count, or 0 when not regulating.
- R8: If en is high, bypass_req is low and either alarm is high at an edge, the mode after that edge is 2'b11 (fast).
- R9: Each alarmed edge reloads a hold counter with hold_ticks. With the alarms clear, each fast tick lowers the hold counter while it is nonzero. The mode returns to slow at the fast tick that finds the hold counter at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Software enable for the regulator |
| bypass_req | input | 1 | Request to close the head switch |
| cmp_low | input | 1 | Main comparator: 1 = output below target |
| alarm_droop | input | 1 | Droop beyond the lower threshold |
| alarm_over | input | 1 | Overshoot beyond the upper threshold |
| slow_div | input | 5 | Clock cycles per tick in slow mode |
| fast_div | input | 5 | Clock cycles per tick in fast mode |
| hold_ticks | input | 8 | Fast ticks held after the alarms clear |
| init_count | input | 4 | Starting switch count when the loop starts |
| sw_en | output | 8 | Thermometer-coded power-switch enables |
| head_sw | output | 1 | Head-switch bypass control |
| status | output | 6 | {mode[1:0], active count[3:0]} |

## Verification
Every output is registered. A change in en, bypass_req or an alarm shows at the outputs one edge after the edge that samples it. A count step appears one edge after the edge that carries a tick. Where that tick falls depends on the divider phase left by earlier cycles. The bench therefore keeps its own cycle model, written from the requirements and advanced at each rising edge. It compares every output at the following falling edge, half a period after the result is due. The sweeps cover divider ratios, hold lengths and starting counts, including ratio 0, a ratio of 1, and a starting value above N_SW.

// File: rtl/dldo_pkg.sv
// Package: shared mode encoding for the adaptive-rate regulator controller.
// Assumes: the 2-bit code is also the mode field of the status word.
package dldo_pkg;
    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_BYP  = 2'd1,
        MODE_SLOW = 2'd2,
        MODE_FAST = 2'd3
    } dldo_mode_e;
endpackage

// File: rtl/dldo_tick_gen.sv
// Module: dldo_tick_gen
// Derives the comparator sampling tick from the fast clock. The ratio is
// chosen by the current rate (slow or fast). A ratio of 0 behaves as 1.
// Assumes: run is low outside regulation, which keeps the phase at zero.
module dldo_tick_gen #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             fast,
    input  logic [DIV_W-1:0] slow_div,
    input  logic [DIV_W-1:0] fast_div,
    output logic             tick
);
    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] ratio_sel;
    logic [DIV_W-1:0] last_phase;

    // Select the active ratio and the phase at which it fires.
    always_comb begin
        ratio_sel  = fast ? fast_div : slow_div;
        last_phase = (ratio_sel == '0) ? '0 : ratio_sel - 1'b1;
    end

    // A rate change to a shorter ratio fires at once (>= compare).
    assign tick = run && (phase_q >= last_phase);

    // Advance the divider phase, restarting on each tick or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (!run || tick)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    a_r5_idle_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> (phase_q == '0));
endmodule

// File: rtl/dldo_mode_fsm.sv
// Module: dldo_mode_fsm
// Sequences off / bypass / slow / fast. Alarms force fast and reload the
// hold counter. Fast ticks with no alarm drain the counter, then drop to slow.
// Assumes: alarms and bypass_req are already synchronous to clk.
module dldo_mode_fsm
    import dldo_pkg::*;
#(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              bypass_req,
    input  logic              alarm_droop,
    input  logic              alarm_over,
    input  logic              tick,
    input  logic [HOLD_W-1:0] hold_ticks,
    output dldo_mode_e        mode_q,
    output logic              run
);
    logic [HOLD_W-1:0] hold_q;
    logic              alarm;

    assign alarm = alarm_droop || alarm_over;
    assign run   = (mode_q == MODE_SLOW) || (mode_q == MODE_FAST);

    // Mode and hold-counter update, in priority order: enable, bypass, start, alarm, tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_OFF;
            hold_q <= '0;
        end else if (!en) begin
            mode_q <= MODE_OFF;
        end else if (bypass_req) begin
            mode_q <= MODE_BYP;
        end else if (!run) begin
            mode_q <= MODE_SLOW;
        end else if (alarm) begin
            mode_q <= MODE_FAST;
            hold_q <= hold_ticks;
        end else if (mode_q == MODE_FAST && tick) begin
            if (hold_q == '0)
                mode_q <= MODE_SLOW;
            else
                hold_q <= hold_q - 1'b1;
        end
    end

    a_r2_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> (mode_q == MODE_OFF));
    a_r3_bypass_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (en && bypass_req) |=> (mode_q == MODE_BYP));
    a_r8_alarm_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !bypass_req && run && alarm) |=> (mode_q == MODE_FAST));
    a_r9_stay_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !bypass_req && mode_q == MODE_FAST && !tick) |=> (mode_q == MODE_FAST));
endmodule

// File: rtl/dldo_switch_count.sv
// Module: dldo_switch_count
// Holds the active power-switch count and steps it by one on each tick. It
// saturates at 0 and N_SW and decodes the count to thermometer enables.
// Assumes: tick is asserted only while run is high.
module dldo_switch_count #(
    parameter int N_SW  = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             cmp_low,
    input  logic [CNT_W-1:0] init_count,
    output logic [CNT_W-1:0] count_q,
    output logic [N_SW-1:0]  sw_en
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(N_SW);

    logic [CNT_W-1:0] start_val;

    // Clamp the programmed starting count to the switch array size.
    assign start_val = (init_count > CNT_MAX) ? CNT_MAX : init_count;

    // Preload while idle; on a tick step up or down with saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (!run)
            count_q <= start_val;
        else if (tick) begin
            if (cmp_low)
                count_q <= (count_q == CNT_MAX) ? count_q : count_q + 1'b1;
            else
                count_q <= (count_q == '0) ? count_q : count_q - 1'b1;
        end
    end

    // Thermometer decode: switch i is on when the count exceeds i.
    for (genvar i = 0; i < N_SW; i++) begin : g_therm
        assign sw_en[i] = run && (count_q > CNT_W'(i));
    end

    a_r5_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(count_q));
    a_r6_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && cmp_low && count_q < CNT_MAX) |=> (count_q == $past(count_q) + 1'b1));
    a_r6_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !cmp_low && count_q != '0) |=> (count_q == $past(count_q) - 1'b1));
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_MAX);
endmodule

// File: rtl/dldo_rate_ctrl.sv
// Module: dldo_rate_ctrl (top)
// Digital LDO control loop with adaptive sampling rate. Ties together the
// mode sequencer, the tick divider and the switch counter. Drives the
// switch enables, the head switch and the status word {mode, count}.
// Assumes: all inputs are synchronous to clk; configuration is quasi-static.
module dldo_rate_ctrl
    import dldo_pkg::*;
#(
    parameter int N_SW   = 8,
    parameter int DIV_W  = 5,
    parameter int HOLD_W = 8,
    localparam int CNT_W = $clog2(N_SW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              bypass_req,
    input  logic              cmp_low,
    input  logic              alarm_droop,
    input  logic              alarm_over,
    input  logic [DIV_W-1:0]  slow_div,
    input  logic [DIV_W-1:0]  fast_div,
    input  logic [HOLD_W-1:0] hold_ticks,
    input  logic [CNT_W-1:0]  init_count,
    output logic [N_SW-1:0]   sw_en,
    output logic              head_sw,
    output logic [CNT_W+1:0]  status
);
    dldo_mode_e       mode_q;
    logic             run;
    logic             tick;
    logic [CNT_W-1:0] count_q;

    dldo_mode_fsm #(.HOLD_W(HOLD_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en), .bypass_req(bypass_req),
        .alarm_droop(alarm_droop), .alarm_over(alarm_over), .tick(tick),
        .hold_ticks(hold_ticks), .mode_q(mode_q), .run(run)
    );

    dldo_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .fast(mode_q == MODE_FAST),
        .slow_div(slow_div), .fast_div(fast_div), .tick(tick)
    );

    dldo_switch_count #(.N_SW(N_SW), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .cmp_low(cmp_low),
        .init_count(init_count), .count_q(count_q), .sw_en(sw_en)
    );

    // Head switch closes only in bypass; status shows the count while regulating.
    assign head_sw = (mode_q == MODE_BYP);
    assign status  = {mode_q, (run ? count_q : CNT_W'(0))};

    a_r7_thermometer: assert property (@(posedge clk) disable iff (!rst_n)
        ((sw_en & (sw_en + 1'b1)) == '0) && ($countones(sw_en) == int'(status[CNT_W-1:0])));
    a_r3_bypass_isolates: assert property (@(posedge clk) disable iff (!rst_n)
        head_sw |-> (sw_en == '0));
    a_r2_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> (!head_sw && sw_en == '0));
endmodule

// File: tb/dldo_rate_ctrl_tb.sv
module dldo_rate_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_SW = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, bypass_req = 1'b0, cmp_low = 1'b0;
    logic       alarm_droop = 1'b0, alarm_over = 1'b0;
    logic [4:0] slow_div = 5'd4, fast_div = 5'd1;
    logic [7:0] hold_ticks = 8'd0;
    logic [3:0] init_count = 4'd0;
    logic [7:0] sw_en;
    logic       head_sw;
    logic [5:0] status;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    dldo_rate_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .bypass_req(bypass_req),
        .cmp_low(cmp_low), .alarm_droop(alarm_droop), .alarm_over(alarm_over),
        .slow_div(slow_div), .fast_div(fast_div), .hold_ticks(hold_ticks),
        .init_count(init_count), .sw_en(sw_en), .head_sw(head_sw), .status(status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Requirement-level model, advanced on each rising edge.
    int m_mode = 0, m_div = 0, m_cnt = 0, m_hold = 0;
    always @(posedge clk) begin
        int ratio, ist;
        bit run, tk;
        if (!rst_n) begin
            m_mode <= 0; m_div <= 0; m_cnt <= 0; m_hold <= 0;
        end else begin
            run   = (m_mode >= 2);
            ratio = (m_mode == 3) ? int'(fast_div) : int'(slow_div);
            if (ratio == 0) ratio = 1;
            tk    = run && (m_div >= ratio - 1);
            ist   = (int'(init_count) > N_SW) ? N_SW : int'(init_count);
            m_div <= (!run || tk) ? 0 : m_div + 1;
            if (!run) m_cnt <= ist;
            else if (tk) m_cnt <= cmp_low ? ((m_cnt == N_SW) ? N_SW : m_cnt + 1)
                                          : ((m_cnt == 0) ? 0 : m_cnt - 1);
            if (!en) m_mode <= 0;
            else if (bypass_req) m_mode <= 1;
            else if (!run) m_mode <= 2;
            else if (alarm_droop || alarm_over) begin
                m_mode <= 3; m_hold <= int'(hold_ticks);
            end else if (m_mode == 3 && tk) begin
                if (m_hold == 0) m_mode <= 2;
                else m_hold <= m_hold - 1;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare all outputs against the model, half a period after the edge.
    task automatic compare_all();
        int cnt_vis, therm;
        string mreq;
        cnt_vis = (m_mode >= 2) ? m_cnt : 0;
        therm   = (1 << cnt_vis) - 1;
        case (m_mode)
            0: mreq = "R2 mode";
            1: mreq = "R3 mode";
            2: mreq = "R4 R9 mode";
            default: mreq = "R8 R9 mode";
        endcase
        chk(mreq, int'(status[5:4]), m_mode);
        chk("R5 R6 count", int'(status[3:0]), cnt_vis);
        chk("R7 sw_en", int'(sw_en), therm);
        chk("R3 head_sw", int'(head_sw), (m_mode == 1) ? 1 : 0);
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        logic [7:0] lfsr = 8'hA5;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 sw_en", int'(sw_en), 0);
        chk("R1 head_sw", int'(head_sw), 0);
        chk("R1 status", int'(status), 0);
        rst_n = 1'b1;

        // Directed R4 R5 R6: init 2, slow ratio 4, cmp_low high.
        slow_div = 5'd4; init_count = 4'd2; cmp_low = 1'b1;
        en = 1'b1;
        step();                                   // edge 1: mode slow, count 2
        chk("R4 start mode", int'(status[5:4]), 2);
        chk("R4 start count", int'(status[3:0]), 2);
        for (int k = 0; k < 3; k++) step();
        chk("R5 no step before tick", int'(status[3:0]), 2);
        step();
        chk("R6 step on tick", int'(status[3:0]), 3);
        en = 1'b0;
        step();
        chk("R2 off count", int'(status), 0);

        // Sweeps over ratios, hold lengths and starting counts.
        for (int s = 0; s < 4; s++) begin
            for (int f = 0; f < 3; f++) begin
                for (int h = 0; h < 3; h++) begin
                    for (int ic = 0; ic < 3; ic++) begin
                        slow_div   = 5'((s == 3) ? 0 : (s == 0 ? 1 : s * 3));
                        fast_div   = 5'(f);
                        hold_ticks = 8'(h * 2);
                        init_count = 4'((ic == 2) ? 11 : ic * 4);
                        for (int k = 0; k < 70; k++) begin
                            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                            en          = !(k < 2 || k == 50);
                            bypass_req  = (k >= 20 && k < 24);
                            alarm_droop = (k == 30 || k == 31 || k == 22);
                            alarm_over  = (k == 40);
                            cmp_low     = (k < 15) ? 1'b1 : ((k > 55) ? 1'b0 : lfsr[0]);
                            step();
                        end
                    end
                end
            end
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule